// File: doc/BRIEF.md
# Fibonacci Sequence Engine

The engine returns the n-th Fibonacci number for an unsigned index n. It works through the sequence one term per clock. It keeps a pair of registers that hold the current term and the term before it. The engine is driven by a block-level handshake: `go_i` asks for a run, and `ready_o` reports that the index has been taken. `done_o` reports that the result is on the outputs, and `idle_o` reports that no request is in flight.

The consumer can hold off the engine with `proceed_i`. When the run finishes while `proceed_i` is low, the engine stays in its finished state with `done_o` high and both outputs frozen. It stays there until the consumer raises `proceed_i`. Besides the result, the engine also returns the preceding Fibonacci term. A consumer can use that pair to resume the sequence without repeating the work.

Top module: `fib_seq_engine`

## Requirements
- R1: After synchronous reset `rst_i`, `idle_o` is 1, and `done_o` and `ready_o` are 0. `res_o` and `prev_o` are 0.
- R2: When `go_i` is high at a rising edge while `idle_o` is high, `ready_o` is 1 for exactly the following cycle. `n_i` is captured at that edge, so later changes to `n_i` do not affect the run.
- R3: For n = 0 the result is 0, and for n = 1 the result is 1. In both cases `prev_o` is 0, and `done_o` rises in the same cycle as the `ready_o` pulse.
- R4: For n >= 2, `res_o` equals F(n) and `prev_o` equals F(n-1), with F(0)=0 and F(1)=1.
- R5: For n >= 2, `done_o` first reads 1 exactly n-1 cycles after the cycle in which `ready_o` is 1.
- R6: While `done_o` is 1 and `proceed_i` is 0, `done_o` stays 1 and `res_o` and `prev_o` hold their values.
- R7: When `proceed_i` is high at an edge while `done_o` is 1, the next cycle shows `done_o` 0 and `idle_o` 1. `idle_o` and `done_o` are never 1 together, and `idle_o` is 0 from the ready cycle until that return.
- R8: `go_i` has no effect while `idle_o` is 0: no `ready_o` pulse follows it, and the run in progress completes with its own result.
- R9: The sums wrap modulo 2^DATA_W. With DATA_W = 32, n = 48 yields 512559680 and prev 2971215073.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Request to start a run |
| n_i | input | CNT_W | Unsigned index of the requested term |
| proceed_i | input | 1 | Consumer accepts the finished result |
| ready_o | output | 1 | One-cycle pulse: index captured |
| done_o | output | 1 | Result valid; held until accepted |
| idle_o | output | 1 | No request in flight |
| res_o | output | DATA_W | F(n) |
| prev_o | output | DATA_W | F(n-1), or 0 for n below 2 |

## Verification
The assertions assume that `go_i` and `proceed_i` are plain levels sampled at the rising edge. They also assume that `n_i` holds steady only up to the capturing edge and need not hold after it. The bench drives every input at the falling edge and drops `go_i` right after it is taken. It scrambles `n_i` once `ready_o` appears, so any late reading of the index would show up as a wrong result. The bench also pulses `go_i` during some runs and keeps `proceed_i` low for several different numbers of cycles. That checks the ignore and hold rules from the outputs alone.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } fib_state_e;

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic go_i,
  input  logic proceed_i,
  input  logic short_i,
  input  logic last_step_i,
  output logic load_o,
  output logic step_o,
  output logic ready_o,
  output logic done_o,
  output logic idle_o
);

  fib_state_e state_q, state_d;
  logic       ready_q;

  assign load_o = (state_q == ST_IDLE) && go_i;
  assign step_o = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i) state_d = short_i ? ST_HOLD : ST_RUN;
      ST_RUN:  if (last_step_i) state_d = ST_HOLD;
      ST_HOLD: if (proceed_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= load_o;
    end
  end

  assign ready_o = ready_q;
  assign done_o  = (state_q == ST_HOLD);
  assign idle_o  = (state_q == ST_IDLE);

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  n_i,
  output logic              last_step_o,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] old_o
);

  logic [DATA_W-1:0] cur_q, old_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_q  <= '0;
      old_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      cur_q  <= (n_i == '0) ? '0 : DATA_W'(1);
      old_q  <= '0;
      left_q <= n_i - CNT_W'(1);
    end else if (step_i) begin
      cur_q  <= cur_q + old_q;
      old_q  <= cur_q;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign last_step_o = (left_q == CNT_W'(1));
  assign cur_o       = cur_q;
  assign old_o       = old_q;

endmodule

// File: rtl/fib_seq_engine.sv
module fib_seq_engine #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic              proceed_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              idle_o,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] prev_o
);

  logic load_w, step_w, last_step_w, short_w;

  assign short_w = (n_i < CNT_W'(2));

  fib_ctrl ctrl_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .go_i        (go_i),
    .proceed_i   (proceed_i),
    .short_i     (short_w),
    .last_step_i (last_step_w),
    .load_o      (load_w),
    .step_o      (step_w),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .idle_o      (idle_o)
  );

  fib_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (load_w),
    .step_i      (step_w),
    .n_i         (n_i),
    .last_step_o (last_step_w),
    .cur_o       (res_o),
    .old_o       (prev_o)
  );

endmodule

// File: rtl/fib_seq_engine_chk.sv
module fib_seq_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              go_i,
  input logic              proceed_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              idle_o,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W-1:0] prev_o
);

  // R2
  ready_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |=> !ready_o);

  // R2
  ready_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |-> $past(go_i && idle_o));

  // R3
  short_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && done_o) |-> (prev_o == '0 && res_o <= DATA_W'(1)));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !proceed_i) |=> (done_o && $stable(res_o) && $stable(prev_o)));

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && proceed_i) |=> (idle_o && !done_o));

  // R7
  idle_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(idle_o && done_o));

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!idle_o && go_i) |=> !ready_o);

endmodule

bind fib_seq_engine fib_seq_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .go_i      (go_i),
  .proceed_i (proceed_i),
  .ready_o   (ready_o),
  .done_o    (done_o),
  .idle_o    (idle_o),
  .res_o     (res_o),
  .prev_o    (prev_o)
);

// File: tb/fib_seq_engine_tb_top.sv
module fib_seq_engine_tb_top;
  localparam int DW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          go;
  logic [CW-1:0] n;
  logic          proceed;
  logic          ready, done, idle;
  logic [DW-1:0] res, prev;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fib_seq_engine #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_i(rst), .go_i(go), .n_i(n), .proceed_i(proceed),
    .ready_o(ready), .done_o(done), .idle_o(idle), .res_o(res), .prev_o(prev)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  task automatic run(input int idx, input int hold, input bit poke);
    logic [DW-1:0] a, b, t, ep;
    int lat, exp_lat;
    a = '0; b = DW'(1);
    for (int i = 0; i < idx; i++) begin t = a + b; a = b; b = t; end
    ep = (idx < 2) ? '0 : b - a;
    exp_lat = (idx < 2) ? 0 : idx - 1;
    @(negedge clk);
    n = CW'(idx); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R2 ready pulse", ready, 1);
    chk("R7 idle low in ready cycle", idle, 0);
    n = CW'(idx + 7);
    lat = 0;
    while (!done && lat < idx + 5) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1 && !done) go = 1'b1;
      else go = 1'b0;
      chk("R2/R8 no extra ready", ready, 0);
    end
    go = 1'b0;
    if (idx < 2) chk("R3 done with ready", lat, 0);
    else chk("R5 latency", lat, exp_lat);
    chk(idx < 2 ? "R3 result" : (idx >= 48 ? "R9 wrapped result" : "R4 result"), res, a);
    chk(idx < 2 ? "R3 prev" : "R4 prev", prev, ep);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R6 done held", done, 1);
      chk("R6 result held", res, a);
      chk("R6 prev held", prev, ep);
    end
    proceed = 1'b1;
    @(negedge clk);
    proceed = 1'b0;
    chk("R7 done cleared", done, 0);
    chk("R7 back to idle", idle, 1);
  endtask

  initial begin
    rst = 1'b1; go = 1'b0; n = '0; proceed = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 idle", idle, 1);
    chk("R1 done", done, 0);
    chk("R1 ready", ready, 0);
    chk("R1 res", res, 0);
    chk("R1 prev", prev, 0);
    for (int k = 0; k <= 40; k++) run(k, k % 4, (k % 3) == 0);
    run(47, 2, 1'b1);
    run(48, 1, 1'b0);
    run(60, 0, 1'b1);
    run(1, 3, 1'b0);
    run(0, 0, 1'b0);
    summary();
  end

endmodule